// File: doc/BRIEF.md
# Integer Execute Unit

This block is the combinational execute stage of a small 32-bit integer core. In one pass it takes a fetched instruction word, the two source operand values read from the register file, and the address of the instruction. It decodes the opcode and function fields and builds whichever sign-extended immediate the format carries. It then produces the value to be written back, a write strobe, a control-transfer flag, the address of the next instruction, and the effective address of a word load or store.

The supported operations are register and immediate arithmetic, logic, compare and shift; upper-immediate load and PC-relative upper add; the two jump-and-link forms; the six conditional branches; and word load and store. A load does not assert the write strobe here, because its data arrives later from memory; the load only produces its address. Any encoding outside this set raises an illegal flag and has no architectural effect.

Top module: `int_exec_unit`

## Requirements
- R1: Add and subtract wrap modulo 2^32 with no overflow signal. Register form (opcode 0110011, funct3 000) subtracts when funct7 is 0100000 and adds when it is 0000000. The immediate form (opcode 0010011, funct3 000) always adds the sign-extended 12-bit immediate from bits 31:20, even when bit 30 is set.
- R2: For opcodes 0110011 and 0010011, funct3 111, 110 and 100 give bitwise AND, OR and XOR of rs1 with rs2 or with the sign-extended immediate.
- R3: Funct3 010 gives a signed less-than result and funct3 011 an unsigned one, written as 1 or 0 in the full word. The unsigned immediate compare uses the sign-extended immediate.
- R4: Funct3 001 shifts left and funct3 101 shifts right, filling with zeros, or with copies of bit 31 when instruction bit 30 is 1. The register form uses only rs2[4:0] as the amount, and the immediate form uses instruction bits 24:20.
- R5: Opcode 0110111 writes bits 31:12 of the instruction with twelve zero bits below them. Opcode 0010111 writes the PC plus that value, wrapping at 2^32.
- R6: Opcode 1101111 writes PC+4, asserts the taken flag and sets next_pc to PC plus the J-immediate {inst[31], inst[19:12], inst[20], inst[30:21], 0}.
- R7: Opcode 1100111 with funct3 000 writes PC+4, asserts the taken flag and sets next_pc to rs1 plus the sign-extended I-immediate with bit 0 cleared.
- R8: Opcode 1100011 compares rs1 with rs2: funct3 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. If the condition holds, taken is 1 and next_pc is PC plus the B-immediate {inst[31], inst[7], inst[30:25], inst[11:8], 0}. Otherwise next_pc is PC+4. A branch never writes.
- R9: Load (opcode 0000011) and store (opcode 0100011), both with funct3 010, drive mem_addr with rs1 plus the sign-extended I-immediate or S-immediate {inst[31:25], inst[11:7]} and do not write. For every other instruction mem_addr is zero.
- R10: Every instruction other than a jump or a taken branch leaves taken at 0 and next_pc at PC+4.
- R11: These encodings raise illegal, hold wr_en and taken at 0, set next_pc to PC+4 and mem_addr to 0:
  - an unknown opcode;
  - funct7 0100000 on a register op other than funct3 000 or 101, or any other funct7 on a register op;
  - a non-zero funct7 on a left-shift immediate;
  - a funct7 other than 0000000 or 0100000 on a right-shift immediate;
  - funct3 010 or 011 on a branch;
  - a jump-register funct3 other than 000;
  - a load or store funct3 other than 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | First source operand |
| rs2_val | input | XLEN | Second source operand |
| pc | input | XLEN | Address of the instruction |
| wr_data | output | XLEN | Value to write to the destination register |
| wr_en | output | 1 | Destination write strobe |
| taken | output | 1 | Jump or taken branch |
| next_pc | output | XLEN | Address of the next instruction |
| mem_addr | output | XLEN | Effective address for a word load or store, else zero |
| illegal | output | 1 | Unrecognised encoding |

## Verification
The bench builds the unit with its default word width of 32. At that width the interesting edges can be reached directly:
- the add and AUIPC carry out of bit 31 wraps to zero or to the top value;
- shift amounts with bits above bit 4 set show that those bits are ignored;
- operands with bit 31 set separate the signed compares and branches from the unsigned ones;
- negative immediates reach back across the PC, and a jump-register target with bit 0 set shows that the bit is cleared.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

    localparam int ILEN = 32;

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_UPPER  = 7'b0110111;
    localparam logic [6:0] OPC_PCUP   = 7'b0010111;
    localparam logic [6:0] OPC_JLINK  = 7'b1101111;
    localparam logic [6:0] OPC_JREG   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;

    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
        ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA
    } alu_op_e;

    typedef enum logic [2:0] {IMM_I, IMM_S, IMM_B, IMM_U, IMM_J} imm_kind_e;

    typedef enum logic [1:0] {WB_ALU, WB_LINK, WB_UPPER, WB_PCREL} wb_sel_e;

    typedef enum logic [1:0] {FLOW_SEQ, FLOW_BRANCH, FLOW_JLINK, FLOW_JREG} flow_e;

    typedef struct packed {
        alu_op_e   alu_op;
        logic      use_imm;
        imm_kind_e imm_kind;
        wb_sel_e   wb_sel;
        flow_e     flow;
        logic      wr_en;
        logic      mem_op;
        logic      illegal;
    } ctrl_t;

    function automatic alu_op_e pick_alu(input logic [2:0] f3, input logic alt);
        case (f3)
            3'b000:  return alt ? ALU_SUB : ALU_ADD;
            3'b001:  return ALU_SLL;
            3'b010:  return ALU_SLT;
            3'b011:  return ALU_SLTU;
            3'b100:  return ALU_XOR;
            3'b101:  return alt ? ALU_SRA : ALU_SRL;
            3'b110:  return ALU_OR;
            default: return ALU_AND;
        endcase
    endfunction

endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
    import iexu_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output ctrl_t      ctrl
);
    logic f7_ok;

    always_comb begin
        ctrl          = '0;
        ctrl.alu_op   = ALU_ADD;
        ctrl.imm_kind = IMM_I;
        ctrl.wb_sel   = WB_ALU;
        ctrl.flow     = FLOW_SEQ;
        f7_ok         = 1'b1;
        case (opcode)
            OPC_REG: begin
                f7_ok = (funct7 == F7_BASE) ||
                        ((funct7 == F7_ALT) && ((funct3 == 3'b000) || (funct3 == 3'b101)));
                ctrl.alu_op  = pick_alu(funct3, funct7[5]);
                ctrl.wr_en   = 1'b1;
                ctrl.illegal = !f7_ok;
            end
            OPC_IMM: begin
                if (funct3 == 3'b001)
                    f7_ok = (funct7 == F7_BASE);
                else if (funct3 == 3'b101)
                    f7_ok = (funct7 == F7_BASE) || (funct7 == F7_ALT);
                ctrl.alu_op  = pick_alu(funct3, (funct3 == 3'b101) && funct7[5]);
                ctrl.use_imm = 1'b1;
                ctrl.wr_en   = 1'b1;
                ctrl.illegal = !f7_ok;
            end
            OPC_UPPER: begin
                ctrl.imm_kind = IMM_U;
                ctrl.wb_sel   = WB_UPPER;
                ctrl.wr_en    = 1'b1;
            end
            OPC_PCUP: begin
                ctrl.imm_kind = IMM_U;
                ctrl.wb_sel   = WB_PCREL;
                ctrl.wr_en    = 1'b1;
            end
            OPC_JLINK: begin
                ctrl.imm_kind = IMM_J;
                ctrl.wb_sel   = WB_LINK;
                ctrl.flow     = FLOW_JLINK;
                ctrl.wr_en    = 1'b1;
            end
            OPC_JREG: begin
                ctrl.use_imm = 1'b1;
                ctrl.wb_sel  = WB_LINK;
                ctrl.flow    = FLOW_JREG;
                ctrl.wr_en   = 1'b1;
                ctrl.illegal = (funct3 != 3'b000);
            end
            OPC_BRANCH: begin
                ctrl.imm_kind = IMM_B;
                ctrl.flow     = FLOW_BRANCH;
                ctrl.illegal  = (funct3 == 3'b010) || (funct3 == 3'b011);
            end
            OPC_LOAD: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_op  = 1'b1;
                ctrl.illegal = (funct3 != 3'b010);
            end
            OPC_STORE: begin
                ctrl.use_imm  = 1'b1;
                ctrl.imm_kind = IMM_S;
                ctrl.mem_op   = 1'b1;
                ctrl.illegal  = (funct3 != 3'b010);
            end
            default: ctrl.illegal = 1'b1;
        endcase
        if (ctrl.illegal) begin
            ctrl.wr_en  = 1'b0;
            ctrl.mem_op = 1'b0;
            ctrl.flow   = FLOW_SEQ;
        end
    end
endmodule

// File: rtl/iexu_immgen.sv
module iexu_immgen
    import iexu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:7] ifield,
    input  imm_kind_e       kind,
    output logic [XLEN-1:0] imm
);
    logic signed [ILEN-1:0] raw;

    always_comb begin
        case (kind)
            IMM_S:   raw = {{20{ifield[31]}}, ifield[31:25], ifield[11:7]};
            IMM_B:   raw = {{20{ifield[31]}}, ifield[7], ifield[30:25], ifield[11:8], 1'b0};
            IMM_U:   raw = {ifield[31:12], 12'b0};
            IMM_J:   raw = {{12{ifield[31]}}, ifield[19:12], ifield[20], ifield[30:21], 1'b0};
            default: raw = {{20{ifield[31]}}, ifield[31:20]};
        endcase
        imm = XLEN'(raw);
    end
endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
    import iexu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res
);
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] sh;
    assign sh = b[SHW-1:0];

    always_comb begin
        res = '0;
        case (op)
            ALU_ADD:  res = a + b;
            ALU_SUB:  res = a - b;
            ALU_AND:  res = a & b;
            ALU_OR:   res = a | b;
            ALU_XOR:  res = a ^ b;
            ALU_SLT:  res[0] = $signed(a) < $signed(b);
            ALU_SLTU: res[0] = a < b;
            ALU_SLL:  res = a << sh;
            ALU_SRL:  res = a >> sh;
            ALU_SRA:  res = $signed(a) >>> sh;
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/iexu_branch.sv
module iexu_branch #(
    parameter int XLEN = 32
) (
    input  logic [2:0]      funct3,
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    output logic            cond
);
    logic eq, lt_s, lt_u;

    assign eq   = (lhs == rhs);
    assign lt_s = $signed(lhs) < $signed(rhs);
    assign lt_u = lhs < rhs;

    always_comb begin
        case (funct3)
            3'b000:  cond = eq;
            3'b001:  cond = !eq;
            3'b100:  cond = lt_s;
            3'b101:  cond = !lt_s;
            3'b110:  cond = lt_u;
            3'b111:  cond = !lt_u;
            default: cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iexu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] wr_data,
    output logic            wr_en,
    output logic            taken,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] mem_addr,
    output logic            illegal
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    ctrl_t           ctrl;
    logic [XLEN-1:0] imm, op_b, alu_res, pc_seq, pc_rel, jreg_tgt;
    logic            br_cond;

    iexu_decode u_decode (
        .opcode (instr[6:0]),
        .funct3 (instr[14:12]),
        .funct7 (instr[31:25]),
        .ctrl   (ctrl)
    );

    iexu_immgen #(.XLEN(XLEN)) u_immgen (
        .ifield (instr[31:7]),
        .kind   (ctrl.imm_kind),
        .imm    (imm)
    );

    assign op_b = ctrl.use_imm ? imm : rs2_val;

    iexu_alu #(.XLEN(XLEN)) u_alu (
        .op  (ctrl.alu_op),
        .a   (rs1_val),
        .b   (op_b),
        .res (alu_res)
    );

    iexu_branch #(.XLEN(XLEN)) u_branch (
        .funct3 (instr[14:12]),
        .lhs    (rs1_val),
        .rhs    (rs2_val),
        .cond   (br_cond)
    );

    assign pc_seq   = pc + STEP;
    assign pc_rel   = pc + imm;
    assign jreg_tgt = {alu_res[XLEN-1:1], 1'b0};

    always_comb begin
        case (ctrl.wb_sel)
            WB_LINK:  wr_data = pc_seq;
            WB_UPPER: wr_data = imm;
            WB_PCREL: wr_data = pc_rel;
            default:  wr_data = alu_res;
        endcase
    end

    always_comb begin
        case (ctrl.flow)
            FLOW_JLINK:  begin taken = 1'b1;    next_pc = pc_rel;   end
            FLOW_JREG:   begin taken = 1'b1;    next_pc = jreg_tgt; end
            FLOW_BRANCH: begin taken = br_cond; next_pc = br_cond ? pc_rel : pc_seq; end
            default:     begin taken = 1'b0;    next_pc = pc_seq;   end
        endcase
    end

    assign wr_en    = ctrl.wr_en;
    assign illegal  = ctrl.illegal;
    assign mem_addr = ctrl.mem_op ? alu_res : '0;
endmodule

// File: rtl/iexu_chk.sv
module iexu_chk #(
    parameter int XLEN = 32
) (
    input logic [31:0]     instr,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] wr_data,
    input logic            wr_en,
    input logic            taken,
    input logic [XLEN-1:0] next_pc,
    input logic [XLEN-1:0] mem_addr,
    input logic            illegal
);
    logic [6:0] opc;
    logic       is_mem, is_cmp;

    assign opc    = instr[6:0];
    assign is_mem = (opc == 7'b0000011) || (opc == 7'b0100011);
    assign is_cmp = ((opc == 7'b0110011) || (opc == 7'b0010011)) && (instr[14:13] == 2'b01);

    always_comb begin
        if (illegal) begin
            assert_illegal_quiet_R11: assert (!wr_en && !taken && mem_addr == '0)
                else $error("illegal encoding had an effect");
        end
        if (!taken) begin
            assert_fallthrough_R10: assert (next_pc == pc + XLEN'(4))
                else $error("fall-through next_pc wrong");
        end
        if (opc == 7'b1100111 && !illegal) begin
            assert_jreg_even_R7: assert (taken && !next_pc[0])
                else $error("jump-register target odd or not taken");
        end
        if (opc == 7'b1100011) begin
            assert_branch_nowrite_R8: assert (!wr_en)
                else $error("branch wrote a register");
        end
        if (is_mem) begin
            assert_mem_nowrite_R9: assert (!wr_en)
                else $error("load/store asserted write");
        end else begin
            assert_mem_idle_R9: assert (mem_addr == '0)
                else $error("mem_addr non-zero outside load/store");
        end
        if (is_cmp && wr_en) begin
            assert_cmp_bool_R3: assert (wr_data[XLEN-1:1] == '0)
                else $error("compare result not 0/1");
        end
    end
endmodule

bind int_exec_unit iexu_chk #(.XLEN(XLEN)) u_chk (
    .instr    (instr),
    .pc       (pc),
    .wr_data  (wr_data),
    .wr_en    (wr_en),
    .taken    (taken),
    .next_pc  (next_pc),
    .mem_addr (mem_addr),
    .illegal  (illegal)
);

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;

    localparam int XLEN = 32;

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [2:0] f3);
        return {f7, 5'd2, 5'd1, f3, 5'd5, 7'b0110011};
    endfunction
    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [2:0] f3, input logic [6:0] op);
        return {imm, 5'd1, f3, 5'd5, op};
    endfunction
    function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [2:0] f3);
        return {imm[11:5], 5'd2, 5'd1, f3, imm[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_b(input logic [12:0] imm, input logic [2:0] f3);
        return {imm[12], imm[10:5], 5'd2, 5'd1, f3, imm[4:1], imm[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] enc_u(input logic [19:0] imm, input logic [6:0] op);
        return {imm, 5'd5, op};
    endfunction
    function automatic logic [31:0] enc_j(input logic [20:0] imm);
        return {imm[20], imm[10:1], imm[11], imm[19:12], 5'd5, 7'b1101111};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] pc;
        logic [31:0] wd;
        logic        we;
        logic        tk;
        logic [31:0] npc;
        logic [31:0] ma;
        logic        il;
        logic [7:0]  req;
    } vec_t;

    localparam logic [6:0] OI = 7'b0010011;
    localparam logic [31:0] P  = 32'h0000_1000;
    localparam logic [31:0] P4 = 32'h0000_1004;
    localparam int NV = 33;

    // fields: ins, a, b, pc, wd, we, tk, npc, ma, il, req
    localparam vec_t VEC [NV] = '{
        '{enc_r(7'h00, 3'b000), 32'h7FFF_FFFF, 32'h1, P, 32'h8000_0000, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd1},  // R1 add wraps
        '{enc_r(7'h20, 3'b000), 32'h0, 32'h1, P, 32'hFFFF_FFFF, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd1},          // R1 sub wraps
        '{enc_i(12'hFFF, 3'b000, OI), 32'h5, 32'h0, P, 32'h4, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd1},            // R1 addi -1
        '{enc_i(12'h400, 3'b000, OI), 32'h10, 32'h0, P, 32'h410, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd1},         // R1 bit30 still adds
        '{enc_r(7'h00, 3'b111), 32'hF0F0_F0F0, 32'hFF00_FF00, P, 32'hF000_F000, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd2}, // R2 and
        '{enc_i(12'h800, 3'b110, OI), 32'h0000_000F, 32'h0, P, 32'hFFFF_F80F, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd2},   // R2 ori
        '{enc_r(7'h00, 3'b100), 32'hFFFF_0000, 32'h0F0F_0F0F, P, 32'hF0F0_0F0F, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd2}, // R2 xor
        '{enc_r(7'h00, 3'b010), 32'hFFFF_FFFF, 32'h1, P, 32'h1, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd3},          // R3 slt
        '{enc_r(7'h00, 3'b011), 32'hFFFF_FFFF, 32'h1, P, 32'h0, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd3},          // R3 sltu
        '{enc_i(12'hFFF, 3'b011, OI), 32'h5, 32'h0, P, 32'h1, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd3},            // R3 sltiu sext
        '{enc_r(7'h20, 3'b101), 32'h8000_0000, 32'h24, P, 32'hF800_0000, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd4}, // R4 sra low5
        '{enc_r(7'h00, 3'b101), 32'h8000_0000, 32'h24, P, 32'h0800_0000, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd4}, // R4 srl
        '{enc_r(7'h00, 3'b001), 32'h1, 32'h3F, P, 32'h8000_0000, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd4},         // R4 sll 31
        '{enc_i(12'h408, 3'b101, OI), 32'h8000_0010, 32'h0, P, 32'hFF80_0000, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd4}, // R4 srai
        '{enc_u(20'hABCDE, 7'b0110111), 32'h0, 32'h0, P, 32'hABCD_E000, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd5},  // R5 upper
        '{enc_u(20'h00001, 7'b0010111), 32'h0, 32'h0, P, 32'h2000, 1'b1, 1'b0, P4, 32'h0, 1'b0, 8'd5},       // R5 pc add
        '{enc_u(20'h00001, 7'b0010111), 32'h0, 32'h0, 32'hFFFF_F000, 32'h0, 1'b1, 1'b0, 32'hFFFF_F004, 32'h0, 1'b0, 8'd5}, // R5 wrap
        '{enc_j(21'h1FFFF8), 32'h0, 32'h0, P, P4, 1'b1, 1'b1, 32'h0FF8, 32'h0, 1'b0, 8'd6},                  // R6 back jump
        '{enc_i(12'h005, 3'b000, 7'b1100111), 32'h2000, 32'h0, P, P4, 1'b1, 1'b1, 32'h2004, 32'h0, 1'b0, 8'd7}, // R7 bit0 clear
        '{enc_i(12'h000, 3'b000, 7'b1100111), 32'h1, 32'h0, P, P4, 1'b1, 1'b1, 32'h0, 32'h0, 1'b0, 8'd7},    // R7 odd base
        '{enc_b(13'h0010, 3'b000), 32'h3, 32'h3, P, 32'h0, 1'b0, 1'b1, 32'h1010, 32'h0, 1'b0, 8'd8},         // R8 beq taken
        '{enc_b(13'h0010, 3'b001), 32'h3, 32'h3, P, 32'h0, 1'b0, 1'b0, P4, 32'h0, 1'b0, 8'd8},               // R8 bne not
        '{enc_b(13'h1FFC, 3'b100), 32'hFFFF_FFFF, 32'h0, P, 32'h0, 1'b0, 1'b1, 32'h0FFC, 32'h0, 1'b0, 8'd8}, // R8 blt
        '{enc_b(13'h0010, 3'b101), 32'hFFFF_FFFF, 32'h0, P, 32'h0, 1'b0, 1'b0, P4, 32'h0, 1'b0, 8'd8},       // R8 bge not
        '{enc_b(13'h0010, 3'b110), 32'hFFFF_FFFF, 32'h0, P, 32'h0, 1'b0, 1'b0, P4, 32'h0, 1'b0, 8'd8},       // R8 bltu not
        '{enc_b(13'h0800, 3'b111), 32'hFFFF_FFFF, 32'h0, P, 32'h0, 1'b0, 1'b1, 32'h1800, 32'h0, 1'b0, 8'd8}, // R8 bgeu
        '{enc_i(12'hFFC, 3'b010, 7'b0000011), 32'h100, 32'h0, P, 32'h0, 1'b0, 1'b0, P4, 32'h0FC, 1'b0, 8'd9}, // R9 load
        '{enc_s(12'h010, 3'b010), 32'h100, 32'h55, P, 32'h0, 1'b0, 1'b0, P4, 32'h110, 1'b0, 8'd9},           // R9 store
        '{enc_u(20'h0, 7'h7F), 32'h1, 32'h1, P, 32'h0, 1'b0, 1'b0, P4, 32'h0, 1'b1, 8'd11},                  // R11 opcode
        '{enc_r(7'h20, 3'b111), 32'h1, 32'h1, P, 32'h0, 1'b0, 1'b0, P4, 32'h0, 1'b1, 8'd11},                 // R11 funct7
        '{enc_b(13'h0010, 3'b010), 32'h3, 32'h3, P, 32'h0, 1'b0, 1'b0, P4, 32'h0, 1'b1, 8'd11},              // R11 branch f3
        '{enc_i(12'h405, 3'b001, OI), 32'h1, 32'h0, P, 32'h0, 1'b0, 1'b0, P4, 32'h0, 1'b1, 8'd11},           // R11 slli f7
        '{enc_i(12'h010, 3'b000, 7'b0000011), 32'h100, 32'h0, P, 32'h0, 1'b0, 1'b0, P4, 32'h0, 1'b1, 8'd11}  // R11 load f3
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] rs1_val = '0, rs2_val = '0, pc = '0;
    logic [XLEN-1:0] wr_data, next_pc, mem_addr;
    logic            wr_en, taken, illegal;
    int              checks = 0;
    int              errors = 0;
    bit              done = 1'b0;

    always #2.5 clk = ~clk;

    int_exec_unit #(.XLEN(XLEN)) u_dut (
        .instr    (instr),
        .rs1_val  (rs1_val),
        .rs2_val  (rs2_val),
        .pc       (pc),
        .wr_data  (wr_data),
        .wr_en    (wr_en),
        .taken    (taken),
        .next_pc  (next_pc),
        .mem_addr (mem_addr),
        .illegal  (illegal)
    );

    task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b, input logic [31:0] p);
        @(negedge clk);
        instr = i; rs1_val = a; rs2_val = b; pc = p;
        @(posedge clk);
        #1;
    endtask

    task automatic run_vec(input vec_t v);
        apply(v.ins, v.a, v.b, v.pc);
        chk("illegal", int'(v.req), {31'b0, illegal}, {31'b0, v.il});
        chk("wr_en", int'(v.req), {31'b0, wr_en}, {31'b0, v.we});
        if (v.we) chk("wr_data", int'(v.req), wr_data, v.wd);
        chk("taken", int'(v.req), {31'b0, taken}, {31'b0, v.tk});
        chk("next_pc", int'(v.req), next_pc, v.npc);
        chk("mem_addr", int'(v.req), mem_addr, v.ma);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset state: all-zero word is not a valid encoding (R11)
        apply(32'h0, 32'h0, 32'h0, 32'h0);
        chk("reset illegal", 11, {31'b0, illegal}, 32'h1);
        chk("reset wr_en", 11, {31'b0, wr_en}, 32'h0);

        for (int k = 0; k < NV; k++) run_vec(VEC[k]);

        // R10: ordinary ops never redirect
        apply(enc_i(12'h000, 3'b000, OI), 32'h0, 32'h0, 32'h0000_2000);
        chk("nop taken", 10, {31'b0, taken}, 32'h0);
        chk("nop next_pc", 10, next_pc, 32'h0000_2004);
        apply(enc_r(7'h00, 3'b000), 32'h1, 32'h1, 32'hFFFF_FFFC);
        chk("wrap next_pc", 10, next_pc, 32'h0);

        // R4: rs2 bits above 4 ignored by register shift
        apply(enc_r(7'h00, 3'b001), 32'h3, 32'hFFFF_FFE1, 32'h0);
        chk("sll high bits", 4, wr_data, 32'h6);

        // R7: jump-register with bad funct3 is illegal (R11)
        apply(enc_i(12'h0, 3'b001, 7'b1100111), 32'h40, 32'h0, P);
        chk("jreg f3 illegal", 11, {31'b0, illegal}, 32'h1);
        chk("jreg f3 taken", 11, {31'b0, taken}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule